// File: doc/BRIEF.md
# Last-Level Cache Tag Array with Core-Hit Locality Hints

This block holds the tags, valid bits and true-LRU replacement state of a set-associative last-level cache. Core requests look up a line and either hit (the line becomes most recently used) or miss and allocate. Allocating into a full set evicts the least recently used way and raises a back-invalidate for the evicted line, so the smaller core caches never keep a line the LLC has dropped.

The second input is a stream of data-free locality hints. A core cache sends one for every hit at the level picked by a configuration input (first or second level). A hint that finds its line promotes that line to most recently used and changes nothing else. A hint that misses is dropped. Hints keep lines that the core caches use heavily from ageing out of the LLC just because the LLC itself never sees those accesses.

A demand request always wins the single lookup port. A hint that arrives in the same cycle waits in a one-entry buffer and is applied in the next cycle that has no demand request.

Top module: `llc_hint_lru`

## Requirements
- R1: After reset every line is invalid and all outputs are low. The first demand request therefore misses with no victim.
- R2: A demand request whose tag matches a valid way in its set gives resp_valid=1 and resp_hit=1 in the cycle after it is accepted, and that way becomes most recently used.
- R3: A demand miss writes the tag into the lowest-numbered invalid way of the set. If no way is invalid it writes into the least recently used way. Either way, the filled way becomes most recently used.
- R4: A demand miss that replaces a valid line sets victim_valid and binv_valid for one cycle, in the response cycle. Both addresses carry the evicted line address {old tag, set index}. The set index is in the low $clog2(SETS) bits.
- R5: A hint whose hint_lvl equals cfg_hint_lvl and whose line is present promotes that line to most recently used, so that line is not the next victim of its set.
- R6: A hint that misses changes no tag or valid bit. A later demand request to that address misses.
- R7: A hint whose hint_lvl differs from cfg_hint_lvl has no effect. The encoding is 0 for a first-level core hit and 1 for a second-level core hit.
- R8: When a demand request and an accepted hint arrive in the same cycle, the demand request is processed first. The hint is held in a one-entry buffer and applied in the next cycle without a demand request.
- R9: If the buffer is full and a demand request and a new accepted hint arrive together, the new hint is dropped and the buffered one is kept.
- R10: Promoting a way sets its age to 0 and adds one to every way in the set that was younger than it. The ages in a set stay a permutation of 0..WAYS-1.
- R11: Hints never produce resp_valid, victim_valid or binv_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Demand request present |
| req_addr | input | ADDR_W | Demand line address {tag, set} |
| hint_valid | input | 1 | Locality hint present |
| hint_lvl | input | 1 | Core level that hit: 0 first, 1 second |
| hint_addr | input | ADDR_W | Hinted line address |
| cfg_hint_lvl | input | 1 | Core level whose hints are honoured |
| resp_valid | output | 1 | Response to a demand request |
| resp_hit | output | 1 | Demand request hit |
| victim_valid | output | 1 | A valid line was evicted |
| victim_addr | output | ADDR_W | Evicted line address |
| binv_valid | output | 1 | Back-invalidate to core caches |
| binv_addr | output | ADDR_W | Line address to invalidate |

## Verification
A demand request and a locality hint can reach the block in the same cycle. The demand request takes the lookup port, and the hint must either wait in the buffer or be dropped when the buffer is already full. The bench provokes this with directed sequences in which a demand request hits while a hint arrives for another line of the same set. It then reads which way a later miss evicts. That victim address is only correct if the hint was applied late, or discarded, exactly as the requirements say. Random traffic with both inputs often active at once is compared cycle by cycle against a bench model of tags, ages and the buffer.

// File: rtl/llc_hint_pkg.sv
// Shared types for the hint-aware LLC tag array.
// Assumes nothing beyond the standard.
package llc_hint_pkg;
    // Kind of operation granted the single lookup port this cycle.
    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_DEMAND = 2'd1,
        OP_HINT   = 2'd2
    } op_kind_e;
endpackage

// File: rtl/llc_hint_arb.sv
// Picks the operation that uses the lookup port and keeps a one-entry hint buffer.
// Demand requests always win. A hint that loses waits in the buffer. If the
// buffer is full while a demand request holds the port, a new hint is dropped.
// Hints from a core level other than cfg_hint_lvl are filtered out here.
module llc_hint_arb
    import llc_hint_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              hint_valid,
    input  logic              hint_lvl,
    input  logic [ADDR_W-1:0] hint_addr,
    input  logic              cfg_hint_lvl,
    output op_kind_e          op_kind,
    output logic [ADDR_W-1:0] op_addr
);
    logic              hint_ok;
    logic              buf_full;
    logic [ADDR_W-1:0] buf_addr;

    assign hint_ok = hint_valid && (hint_lvl == cfg_hint_lvl);

    // Grant the port: demand first, then the buffered hint, then a fresh hint.
    always_comb begin
        if (req_valid) begin
            op_kind = OP_DEMAND;
            op_addr = req_addr;
        end else if (buf_full) begin
            op_kind = OP_HINT;
            op_addr = buf_addr;
        end else if (hint_ok) begin
            op_kind = OP_HINT;
            op_addr = hint_addr;
        end else begin
            op_kind = OP_NONE;
            op_addr = '0;
        end
    end

    // Fill, keep, refill or drain the one-entry hint buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_full <= 1'b0;
            buf_addr <= '0;
        end else if (req_valid) begin
            if (hint_ok && !buf_full) begin
                buf_full <= 1'b1;
                buf_addr <= hint_addr;
            end
        end else if (buf_full) begin
            if (hint_ok) begin
                buf_addr <= hint_addr;
            end else begin
                buf_full <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/llc_way_lookup.sv
// Tag compare and way choice for one set.
// Gives the hit way, and for a miss the fill way: the lowest invalid way, or
// else the way with the oldest age. Assumes the ages form a permutation.
module llc_way_lookup #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 10,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [WAYS-1:0]            valids,
    input  logic [WAYS-1:0][WAY_W-1:0] ages,
    input  logic [TAG_W-1:0]           tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way,
    output logic [WAY_W-1:0]           fill_way,
    output logic                       fill_evicts
);
    logic [WAYS-1:0] match;

    genvar w;
    generate
        for (w = 0; w < WAYS; w++) begin : g_cmp
            assign match[w] = valids[w] && (tags[w] == tag);
        end
    endgenerate

    // Encode the matching way; tags in a set are unique, so at most one matches.
    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (match[i]) hit_way = WAY_W'(i);
        end
    end

    // Pick the fill way: the lowest invalid way, else the oldest way.
    always_comb begin
        fill_evicts = &valids;
        fill_way    = '0;
        if (fill_evicts) begin
            for (int i = 0; i < WAYS; i++) begin
                if (ages[i] == WAY_W'(WAYS - 1)) fill_way = WAY_W'(i);
            end
        end else begin
            for (int i = WAYS - 1; i >= 0; i--) begin
                if (!valids[i]) fill_way = WAY_W'(i);
            end
        end
    end
endmodule

// File: rtl/llc_age_update.sv
// True-LRU promotion for one set: the chosen way gets age 0, and every way
// younger than its old age ages by one. Keeps a permutation a permutation.
module llc_age_update #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][WAY_W-1:0] ages,
    input  logic [WAY_W-1:0]           sel_way,
    output logic [WAYS-1:0][WAY_W-1:0] new_ages
);
    logic [WAY_W-1:0] sel_age;

    assign sel_age = ages[sel_way];

    genvar w;
    generate
        for (w = 0; w < WAYS; w++) begin : g_age
            assign new_ages[w] = (sel_way == WAY_W'(w)) ? '0 :
                                 (ages[w] < sel_age)    ? ages[w] + 1'b1 :
                                                          ages[w];
        end
    endgenerate
endmodule

// File: rtl/llc_hint_lru.sv
// LLC tag and true-LRU state array that takes demand requests and core-hit hints.
// A demand request looks up its line and allocates on a miss. It reports a
// victim and a back-invalidate when a valid line is replaced. A hint that hits
// only promotes the line. Line addresses are {tag, set}. SETS and WAYS are
// powers of two, and WAYS is at least 2.
module llc_hint_lru
    import llc_hint_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SETS   = 4,
    parameter int WAYS   = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - IDX_W,
    localparam int AGE_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              hint_valid,
    input  logic              hint_lvl,
    input  logic [ADDR_W-1:0] hint_addr,
    input  logic              cfg_hint_lvl,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              victim_valid,
    output logic [ADDR_W-1:0] victim_addr,
    output logic              binv_valid,
    output logic [ADDR_W-1:0] binv_addr
);
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
    logic [SETS-1:0][WAYS-1:0]            valid_q;
    logic [SETS-1:0][WAYS-1:0][AGE_W-1:0] age_q;

    op_kind_e          op_kind;
    logic [ADDR_W-1:0] op_addr;
    logic [IDX_W-1:0]  set_idx;
    logic [TAG_W-1:0]  op_tag;
    logic              hit;
    logic [AGE_W-1:0]  hit_way;
    logic [AGE_W-1:0]  fill_way;
    logic              fill_evicts;
    logic [AGE_W-1:0]  touch_way;
    logic [WAYS-1:0][AGE_W-1:0] new_ages;
    logic              is_demand;
    logic              do_touch;
    logic              do_fill;

    llc_hint_arb #(.ADDR_W(ADDR_W)) u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .hint_valid   (hint_valid),
        .hint_lvl     (hint_lvl),
        .hint_addr    (hint_addr),
        .cfg_hint_lvl (cfg_hint_lvl),
        .op_kind      (op_kind),
        .op_addr      (op_addr)
    );

    assign set_idx = op_addr[IDX_W-1:0];
    assign op_tag  = op_addr[ADDR_W-1:IDX_W];

    llc_way_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
        .tags        (tag_q[set_idx]),
        .valids      (valid_q[set_idx]),
        .ages        (age_q[set_idx]),
        .tag         (op_tag),
        .hit         (hit),
        .hit_way     (hit_way),
        .fill_way    (fill_way),
        .fill_evicts (fill_evicts)
    );

    assign is_demand = (op_kind == OP_DEMAND);
    assign do_fill   = is_demand && !hit;
    assign do_touch  = is_demand || ((op_kind == OP_HINT) && hit);
    assign touch_way = hit ? hit_way : fill_way;

    llc_age_update #(.WAYS(WAYS)) u_age (
        .ages     (age_q[set_idx]),
        .sel_way  (touch_way),
        .new_ages (new_ages)
    );

    // Hold tags, valid bits and ages; reset clears lines and seeds ages to way order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w]   <= '0;
                    valid_q[s][w] <= 1'b0;
                    age_q[s][w]   <= AGE_W'(w);
                end
            end
        end else if (do_touch) begin
            age_q[set_idx] <= new_ages;
            if (do_fill) begin
                tag_q[set_idx][fill_way]   <= op_tag;
                valid_q[set_idx][fill_way] <= 1'b1;
            end
        end
    end

    // Register the demand response, the victim and the back-invalidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid   <= 1'b0;
            resp_hit     <= 1'b0;
            victim_valid <= 1'b0;
            victim_addr  <= '0;
            binv_valid   <= 1'b0;
            binv_addr    <= '0;
        end else begin
            resp_valid   <= is_demand;
            resp_hit     <= is_demand && hit;
            victim_valid <= do_fill && fill_evicts;
            binv_valid   <= do_fill && fill_evicts;
            victim_addr  <= {tag_q[set_idx][fill_way], set_idx};
            binv_addr    <= {tag_q[set_idx][fill_way], set_idx};
        end
    end
endmodule

// File: rtl/llc_hint_lru_chk.sv
// Property checker for llc_hint_lru, attached with bind below.
// It only observes ports and the age array.
module llc_hint_lru_chk #(
    parameter int ADDR_W = 12,
    parameter int SETS   = 4,
    parameter int WAYS   = 4,
    parameter int AGE_W  = 2
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             req_valid,
    input logic                             resp_valid,
    input logic                             resp_hit,
    input logic                             victim_valid,
    input logic [ADDR_W-1:0]                victim_addr,
    input logic                             binv_valid,
    input logic [ADDR_W-1:0]                binv_addr,
    input logic [SETS-1:0][WAYS-1:0][AGE_W-1:0] age_q
);
    logic perm_ok;

    // Check that every set holds each age value exactly once.
    always_comb begin
        logic [WAYS-1:0] seen;
        perm_ok = 1'b1;
        for (int s = 0; s < SETS; s++) begin
            seen = '0;
            for (int w = 0; w < WAYS; w++) seen[age_q[s][w]] = 1'b1;
            if (!(&seen)) perm_ok = 1'b0;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!resp_valid && !binv_valid && !victim_valid));

    // R2
    hit_has_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> resp_valid);

    // R4
    binv_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        binv_valid |-> (resp_valid && !resp_hit));

    // R4
    binv_same_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        binv_valid |-> (victim_valid && (binv_addr == victim_addr)));

    // R11
    resp_needs_demand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(req_valid));

    // R10
    age_permutation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        perm_ok);
endmodule

bind llc_hint_lru llc_hint_lru_chk #(
    .ADDR_W (ADDR_W),
    .SETS   (SETS),
    .WAYS   (WAYS),
    .AGE_W  (AGE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .resp_valid   (resp_valid),
    .resp_hit     (resp_hit),
    .victim_valid (victim_valid),
    .victim_addr  (victim_addr),
    .binv_valid   (binv_valid),
    .binv_addr    (binv_addr),
    .age_q        (age_q)
);

// File: tb/llc_hint_lru_bench.sv
// Bench for llc_hint_lru: directed corner cases, then seeded random traffic,
// all compared against a bench model of tags, ages and the hint buffer.
module llc_hint_lru_bench;
    localparam int ADDR_W = 12;
    localparam int SETS   = 4;
    localparam int WAYS   = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid;
    logic [ADDR_W-1:0] req_addr;
    logic              hint_valid;
    logic              hint_lvl;
    logic [ADDR_W-1:0] hint_addr;
    logic              cfg_hint_lvl;
    logic              resp_valid;
    logic              resp_hit;
    logic              victim_valid;
    logic [ADDR_W-1:0] victim_addr;
    logic              binv_valid;
    logic [ADDR_W-1:0] binv_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Model state.
    int m_tag [SETS][WAYS];
    bit m_val [SETS][WAYS];
    int m_age [SETS][WAYS];
    bit m_bfull;
    int m_baddr;
    bit e_rv, e_hit, e_vv;
    int e_va;

    always #5 clk = ~clk;

    llc_hint_lru #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) u_llc_hint_lru (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .hint_valid   (hint_valid),
        .hint_lvl     (hint_lvl),
        .hint_addr    (hint_addr),
        .cfg_hint_lvl (cfg_hint_lvl),
        .resp_valid   (resp_valid),
        .resp_hit     (resp_hit),
        .victim_valid (victim_valid),
        .victim_addr  (victim_addr),
        .binv_valid   (binv_valid),
        .binv_addr    (binv_addr)
    );

    function automatic int mk(int tag, int set);
        return tag * SETS + set;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_tag[s][w] = 0; m_val[s][w] = 0; m_age[s][w] = w;
            end
        m_bfull = 0; m_baddr = 0;
    endtask

    task automatic model_promote(int s, int w);
        int old = m_age[s][w];
        for (int i = 0; i < WAYS; i++)
            if (m_age[s][i] < old) m_age[s][i]++;
        m_age[s][w] = 0;
    endtask

    // Apply one operation to the model and set the expected outputs.
    task automatic model_op(bit demand, int a);
        int s = a % SETS;
        int t = a / SETS;
        int hw = -1;
        int fw = -1;
        for (int w = 0; w < WAYS; w++)
            if (m_val[s][w] && m_tag[s][w] == t) hw = w;
        if (demand) begin
            e_rv = 1; e_hit = (hw >= 0);
            if (hw >= 0) model_promote(s, hw);
            else begin
                for (int w = WAYS - 1; w >= 0; w--) if (!m_val[s][w]) fw = w;
                if (fw < 0) begin
                    for (int w = 0; w < WAYS; w++) if (m_age[s][w] == WAYS - 1) fw = w;
                    e_vv = 1; e_va = mk(m_tag[s][fw], s);
                end
                m_tag[s][fw] = t; m_val[s][fw] = 1;
                model_promote(s, fw);
            end
        end else if (hw >= 0) begin
            model_promote(s, hw);
        end
    endtask

    // One model cycle, including the hint arbitration and the buffer.
    task automatic model_step(bit rv, int ra, bit hv, bit hl, int ha);
        bit ok = hv && (hl == cfg_hint_lvl);
        e_rv = 0; e_hit = 0; e_vv = 0;
        if (rv) begin
            model_op(1, ra);
            if (ok && !m_bfull) begin m_bfull = 1; m_baddr = ha; end
        end else if (m_bfull) begin
            model_op(0, m_baddr);
            if (ok) m_baddr = ha; else m_bfull = 0;
        end else if (ok) begin
            model_op(0, ha);
        end
    endtask

    task automatic lit(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge and check its registered outputs one cycle later.
    task automatic cyc(string req, bit rv, int ra, bit hv, bit hl, int ha);
        req_valid = rv; req_addr = ADDR_W'(ra);
        hint_valid = hv; hint_lvl = hl; hint_addr = ADDR_W'(ha);
        model_step(rv, ra, hv, hl, ha);
        @(negedge clk);
        req_valid = 0; hint_valid = 0;
        checks++;
        if (resp_valid !== e_rv || resp_hit !== e_hit || victim_valid !== e_vv ||
            binv_valid !== e_vv || (e_vv && (victim_addr !== ADDR_W'(e_va) ||
            binv_addr !== ADDR_W'(e_va)))) begin
            fails++;
            $display("FAIL %s actual rv=%0b hit=%0b vv=%0b va=%0d bv=%0b ba=%0d expected rv=%0b hit=%0b vv=%0b va=%0d",
                     req, resp_valid, resp_hit, victim_valid, victim_addr, binv_valid,
                     binv_addr, e_rv, e_hit, e_vv, e_va);
        end
    endtask

    task automatic idle(string req);
        cyc(req, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        rst_n = 0; req_valid = 0; req_addr = 0; hint_valid = 0;
        hint_lvl = 0; hint_addr = 0; cfg_hint_lvl = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: outputs low right after reset
        lit("R1", int'(resp_valid) + int'(victim_valid) + int'(binv_valid), 0);

        // R1 R3: first demand misses into an empty set, no victim
        cyc("R1", 1, mk(4, 0), 0, 0, 0);
        lit("R1", int'(victim_valid), 0);
        cyc("R2", 1, mk(4, 0), 0, 0, 0);
        lit("R2", int'(resp_hit), 1);

        // R5: fill set 1, hint the oldest line, next miss evicts the second oldest
        for (int t = 1; t <= 4; t++) cyc("R3", 1, mk(t, 1), 0, 0, 0);
        cyc("R5", 0, 0, 1, 0, mk(1, 1));
        cyc("R4", 1, mk(5, 1), 0, 0, 0);
        lit("R5", int'(victim_addr), mk(2, 1));

        // R7: hint from the wrong core level leaves the oldest line as victim
        for (int t = 1; t <= 4; t++) cyc("R3", 1, mk(t, 2), 0, 0, 0);
        cyc("R7", 0, 0, 1, 1, mk(1, 2));
        cyc("R4", 1, mk(5, 2), 0, 0, 0);
        lit("R7", int'(victim_addr), mk(1, 2));

        // R6: a missing hint does not allocate
        cyc("R6", 0, 0, 1, 0, mk(9, 3));
        cyc("R6", 1, mk(9, 3), 0, 0, 0);
        lit("R6", int'(resp_hit), 0);

        // R8: demand and hint together, hint applied in the following idle cycle
        for (int t = 5; t <= 7; t++) cyc("R3", 1, mk(t, 0), 0, 0, 0);
        cyc("R8", 1, mk(5, 0), 1, 0, mk(4, 0));
        lit("R11", int'(resp_hit), 1);
        idle("R8");
        cyc("R8", 1, mk(8, 0), 0, 0, 0);
        lit("R8", int'(victim_addr), mk(6, 0));

        // R9: buffer full during a demand, the second hint is dropped
        cyc("R9", 1, mk(8, 0), 1, 0, mk(7, 0));
        cyc("R9", 1, mk(8, 0), 1, 0, mk(5, 0));
        idle("R9");
        idle("R11");
        cyc("R9", 1, mk(10, 0), 0, 0, 0);
        lit("R9", int'(victim_addr), mk(5, 0));

        // R10: random traffic with both inputs often active, model compared each cycle
        seed = 32'h1bad5eed;
        void'($urandom(seed));
        for (int n = 0; n < 4000; n++) begin
            bit rv = ($urandom % 2) == 0;
            bit hv = ($urandom % 2) == 0;
            bit hl = ($urandom % 2) == 1;
            int ra = mk($urandom % 7, $urandom % SETS);
            int ha = mk($urandom % 7, $urandom % SETS);
            if (n % 700 == 0) cfg_hint_lvl = ~cfg_hint_lvl;
            cyc("R10", rv, ra, hv, hl, ha);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule